// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns one operation request into the ordered stream of bus cycles that a raw NAND flash part expects on its shared I/O lines. A requester presents an operation selector, a 29-bit linear byte address and a bus-width mode (byte-wide or word-wide) on a valid/ready handshake. The block then emits, one per clock, an opening command cycle, the address cycles that the operation needs, and an optional confirming command cycle. Each emitted cycle carries a one-clock strobe and a kind tag. The block ends the sequence with a one-clock `done` pulse.

The device's ready/busy line gates acceptance. Only the status-read and reset operations are taken while the device is busy. Operations that start an array access (read, program, erase, cache-read start) wait after their confirming command until the device has gone busy and come back ready, and only then signal completion. Requests that the chosen width does not support, and selector codes that are not defined, are refused with a one-clock error pulse and put nothing on the bus.

The controller is a single state machine with these states:

| State | Role |
|---|---|
| IDLE | Waits for a request. |
| CMD | Emits the opening command. |
| ADDR | Emits the address cycles. |
| CONF | Emits the confirming command. |
| WAIT_LOW | Waits for the device to go busy. |
| WAIT_HIGH | Waits for the device to return ready. |
| DONE | Pulses `done`. |
| REJECT | Pulses `err`. |

Transitions:
- IDLE→CMD on an accepted legal request; IDLE→REJECT on an accepted refused one.
- CMD→ADDR if the operation has address cycles; otherwise CMD→CONF if it has a confirm, else CMD→DONE.
- ADDR stays in ADDR until the last address index, then goes to CONF or to DONE.
- CONF→WAIT_LOW for operations that wait for the device; otherwise CONF→DONE.
- WAIT_LOW→WAIT_HIGH when `dev_rdy` is low.
- WAIT_HIGH→DONE when `dev_rdy` is high.
- DONE→IDLE and REJECT→IDLE.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset the block is idle: `bus_stb`, `done` and `err` are low, `bus_kind` is 0, and `req_ready` is high while `dev_rdy` is high.
- R2: Selector codes map to an opening opcode and, where present, a confirming opcode, as follows:
  - 0: 00h, confirm 30h.
  - 1: 00h, confirm 35h.
  - 2: 80h, confirm 10h.
  - 3: 80h, confirm 15h.
  - 4: 85h, confirm 10h.
  - 5: 60h, confirm D0h.
  - 6: 05h, confirm E0h.
  - 7: 85h, no confirm.
  - 8: 90h, no confirm.
  - 9: 70h, no confirm.
  - 10: FFh, no confirm.
  - 11: 00h, confirm 31h.
  - 12: 34h, no confirm.
  
  The opening opcode is strobed in the clock after acceptance.
- R3: In byte-wide mode (`wide`=0) the five address bytes are:
  - A[7:0];
  - {4'b0, A[11:8]};
  - A[19:12];
  - A[27:20];
  - {7'b0, A[28]}.
- R4: In word-wide mode (`wide`=1) the five address bytes are:
  - A[7:0];
  - {5'b0, A[10:8]};
  - A[18:11];
  - A[26:19];
  - {7'b0, A[27]}.
  
  Bits 15:8 of `bus_data` are zero on every strobed cycle in either mode.
- R5: The address cycles depend on the selector:
  - codes 0–4 and 11 send all five address bytes;
  - code 5 sends only bytes three to five (the row part);
  - codes 6 and 7 send only bytes one and two (the column part);
  - code 8 sends a single address byte of 00h;
  - codes 9, 10 and 12 send none.
  
  Cycles go out back to back, in the order opcode, address bytes, confirm.
- R6: While `dev_rdy` is low, only codes 9 and 10 (and refused requests) are accepted. Any other request is held with `req_ready` low and produces no bus cycle until `dev_rdy` rises.
- R7: Codes 11 and 12 with `wide`=1, and codes 13 to 15 in either mode, are accepted and refused. `err` pulses for one clock, and no strobe and no `done` follow.
- R8: For codes 0–5 and 11, `done` is raised only after `dev_rdy` has been seen low and then high following the confirming command.
- R9: `done` is a single-clock pulse. For operations that do not wait on the device, it appears in the clock right after the last strobed cycle.
- R10: Each cycle is strobed for exactly one clock. `bus_kind` is 1 for a command cycle and 2 for an address cycle, and is 0 whenever `bus_stb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_op | input | 4 | Operation selector (codes in R2) |
| req_addr | input | 29 | Linear byte address |
| req_wide | input | 1 | 0 = byte-wide part, 1 = word-wide part |
| dev_rdy | input | 1 | Device ready (1) or busy (0) |
| bus_stb | output | 1 | One-clock cycle strobe |
| bus_kind | output | 2 | Cycle kind: 1 command, 2 address |
| bus_data | output | 16 | Value for the I/O lines |
| done | output | 1 | Sequence complete pulse |
| err | output | 1 | Request refused pulse |

## Verification
The hardest situations to reach are those that depend on the device line. The first is a request held off by busy while a status read or reset is allowed through. The second is completion that must not arrive before the device has dropped and restored ready. The bench holds `dev_rdy` low from a forcing flag around chosen requests, and checks each clock that the gated request stays unaccepted and silent. A small device model in the bench drops ready for a random number of clocks whenever it sees a confirm opcode that starts an array access, so the wait states are exercised with varying lengths. Refusals are reached with the cache-read codes in word-wide mode and with the undefined codes, mixed into a seeded random stream.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int ADDR_W  = 29;
    localparam int IDX_W   = 3;

    localparam logic [3:0] OP_PAGE_READ   = 4'd0;
    localparam logic [3:0] OP_READ_CB     = 4'd1;
    localparam logic [3:0] OP_PROG        = 4'd2;
    localparam logic [3:0] OP_CACHE_PROG  = 4'd3;
    localparam logic [3:0] OP_CB_PROG     = 4'd4;
    localparam logic [3:0] OP_ERASE       = 4'd5;
    localparam logic [3:0] OP_RAND_OUT    = 4'd6;
    localparam logic [3:0] OP_RAND_IN     = 4'd7;
    localparam logic [3:0] OP_READ_ID     = 4'd8;
    localparam logic [3:0] OP_STATUS      = 4'd9;
    localparam logic [3:0] OP_RESET       = 4'd10;
    localparam logic [3:0] OP_CREAD_START = 4'd11;
    localparam logic [3:0] OP_CREAD_EXIT  = 4'd12;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_CMD  = 2'd1,
        KIND_ADDR = 2'd2,
        KIND_DATA = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        AM_NONE  = 3'd0,
        AM_ZERO1 = 3'd1,
        AM_COL2  = 3'd2,
        AM_ROW3  = 3'd3,
        AM_FULL5 = 3'd4
    } amode_e;

    typedef struct packed {
        logic [7:0] first;
        logic       has_conf;
        logic [7:0] conf;
        amode_e     amode;
        logic       wait_dev;
        logic       busy_ok;
        logic       reject;
    } desc_t;

endpackage

// File: rtl/nand_op_decode.sv
module nand_op_decode
    import nand_seq_pkg::*;
(
    input  logic [3:0] op,
    input  logic       wide,
    output desc_t      desc
);

    always_comb begin
        desc          = '0;
        desc.amode    = AM_NONE;
        unique case (op)
            OP_PAGE_READ: begin
                desc.first = 8'h00; desc.has_conf = 1'b1; desc.conf = 8'h30;
                desc.amode = AM_FULL5; desc.wait_dev = 1'b1;
            end
            OP_READ_CB: begin
                desc.first = 8'h00; desc.has_conf = 1'b1; desc.conf = 8'h35;
                desc.amode = AM_FULL5; desc.wait_dev = 1'b1;
            end
            OP_PROG: begin
                desc.first = 8'h80; desc.has_conf = 1'b1; desc.conf = 8'h10;
                desc.amode = AM_FULL5; desc.wait_dev = 1'b1;
            end
            OP_CACHE_PROG: begin
                desc.first = 8'h80; desc.has_conf = 1'b1; desc.conf = 8'h15;
                desc.amode = AM_FULL5; desc.wait_dev = 1'b1;
            end
            OP_CB_PROG: begin
                desc.first = 8'h85; desc.has_conf = 1'b1; desc.conf = 8'h10;
                desc.amode = AM_FULL5; desc.wait_dev = 1'b1;
            end
            OP_ERASE: begin
                desc.first = 8'h60; desc.has_conf = 1'b1; desc.conf = 8'hD0;
                desc.amode = AM_ROW3; desc.wait_dev = 1'b1;
            end
            OP_RAND_OUT: begin
                desc.first = 8'h05; desc.has_conf = 1'b1; desc.conf = 8'hE0;
                desc.amode = AM_COL2;
            end
            OP_RAND_IN: begin
                desc.first = 8'h85; desc.amode = AM_COL2;
            end
            OP_READ_ID: begin
                desc.first = 8'h90; desc.amode = AM_ZERO1;
            end
            OP_STATUS: begin
                desc.first = 8'h70; desc.busy_ok = 1'b1;
            end
            OP_RESET: begin
                desc.first = 8'hFF; desc.busy_ok = 1'b1;
            end
            OP_CREAD_START: begin
                desc.first = 8'h00; desc.has_conf = 1'b1; desc.conf = 8'h31;
                desc.amode = AM_FULL5; desc.wait_dev = 1'b1;
                desc.reject = wide;
            end
            OP_CREAD_EXIT: begin
                desc.first = 8'h34;
                desc.reject = wide;
            end
            default: begin
                desc.reject = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/nand_addr_pack.sv
module nand_addr_pack
    import nand_seq_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    input  logic [IDX_W-1:0]  idx,
    output logic [BUS_W-1:0]  word
);

    localparam int PAD_W = BUS_W - 8;

    logic [7:0] byte8;
    logic [7:0] byte16;
    logic [7:0] sel;

    // byte-wide part: 12 column bits, 17 row bits
    always_comb begin
        unique case (idx)
            3'd0:    byte8 = addr[7:0];
            3'd1:    byte8 = {4'b0, addr[11:8]};
            3'd2:    byte8 = addr[19:12];
            3'd3:    byte8 = addr[27:20];
            3'd4:    byte8 = {7'b0, addr[28]};
            default: byte8 = 8'h00;
        endcase
    end

    // word-wide part: 11 column bits, 17 row bits, top address bit unused
    always_comb begin
        unique case (idx)
            3'd0:    byte16 = addr[7:0];
            3'd1:    byte16 = {5'b0, addr[10:8]};
            3'd2:    byte16 = addr[18:11];
            3'd3:    byte16 = addr[26:19];
            3'd4:    byte16 = {7'b0, addr[27]};
            default: byte16 = 8'h00;
        endcase
    end

    assign sel = wide ? byte16 : byte8;

    generate
        if (PAD_W > 0) begin : g_pad
            assign word = {{PAD_W{1'b0}}, sel};
        end else begin : g_nopad
            assign word = sel;
        end
    endgenerate

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wide,
    input  logic              dev_rdy,
    output logic              bus_stb,
    output logic [1:0]        bus_kind,
    output logic [BUS_W-1:0]  bus_data,
    output logic              done,
    output logic              err
);

    localparam int PAD_W = BUS_W - 8;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_CMD       = 3'd1,
        S_ADDR      = 3'd2,
        S_CONF      = 3'd3,
        S_WAIT_LOW  = 3'd4,
        S_WAIT_HIGH = 3'd5,
        S_DONE      = 3'd6,
        S_REJECT    = 3'd7
    } state_e;

    state_e state_q, state_d;

    desc_t              dec;
    logic               take;
    logic [7:0]         first_q, conf_q;
    logic               has_conf_q, wait_q;
    amode_e             amode_q;
    logic [ADDR_W-1:0]  addr_q;
    logic               wide_q;
    logic [IDX_W-1:0]   idx_q, last_q;
    logic [IDX_W-1:0]   idx_start, idx_last;
    logic [BUS_W-1:0]   pack_word;
    logic [BUS_W-1:0]   first_w, conf_w;

    nand_op_decode i_dec (
        .op   (req_op),
        .wide (req_wide),
        .desc (dec)
    );

    nand_addr_pack #(.BUS_W(BUS_W)) i_pack (
        .addr (addr_q),
        .wide (wide_q),
        .idx  (idx_q),
        .word (pack_word)
    );

    generate
        if (PAD_W > 0) begin : g_cmd_pad
            assign first_w = {{PAD_W{1'b0}}, first_q};
            assign conf_w  = {{PAD_W{1'b0}}, conf_q};
        end else begin : g_cmd_nopad
            assign first_w = first_q;
            assign conf_w  = conf_q;
        end
    endgenerate

    assign req_ready = (state_q == S_IDLE) && (dev_rdy || dec.busy_ok || dec.reject);
    assign take      = req_valid && req_ready;

    // address window per mode
    always_comb begin
        unique case (amode_q)
            AM_FULL5: begin idx_start = 3'd0; idx_last = 3'd4; end
            AM_COL2:  begin idx_start = 3'd0; idx_last = 3'd1; end
            AM_ROW3:  begin idx_start = 3'd2; idx_last = 3'd4; end
            AM_ZERO1: begin idx_start = 3'd0; idx_last = 3'd0; end
            default:  begin idx_start = 3'd0; idx_last = 3'd0; end
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (take) state_d = dec.reject ? S_REJECT : S_CMD;
            end
            S_CMD: begin
                if (amode_q != AM_NONE) state_d = S_ADDR;
                else if (has_conf_q)    state_d = S_CONF;
                else                    state_d = S_DONE;
            end
            S_ADDR: begin
                if (idx_q == last_q) state_d = has_conf_q ? S_CONF : S_DONE;
            end
            S_CONF: begin
                state_d = wait_q ? S_WAIT_LOW : S_DONE;
            end
            S_WAIT_LOW: begin
                if (!dev_rdy) state_d = S_WAIT_HIGH;
            end
            S_WAIT_HIGH: begin
                if (dev_rdy) state_d = S_DONE;
            end
            S_DONE:   state_d = S_IDLE;
            S_REJECT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // request capture and address index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q    <= '0;
            conf_q     <= '0;
            has_conf_q <= 1'b0;
            wait_q     <= 1'b0;
            amode_q    <= AM_NONE;
            addr_q     <= '0;
            wide_q     <= 1'b0;
            idx_q      <= '0;
            last_q     <= '0;
        end else begin
            if (state_q == S_IDLE && take) begin
                first_q    <= dec.first;
                conf_q     <= dec.conf;
                has_conf_q <= dec.has_conf;
                wait_q     <= dec.wait_dev;
                amode_q    <= dec.amode;
                addr_q     <= req_addr;
                wide_q     <= req_wide;
            end
            if (state_q == S_CMD) begin
                idx_q  <= idx_start;
                last_q <= idx_last;
            end else if (state_q == S_ADDR && idx_q != last_q) begin
                idx_q <= idx_q + 3'd1;
            end
        end
    end

    // outputs, decoded from the registered state
    always_comb begin
        bus_stb  = 1'b0;
        bus_kind = KIND_NONE;
        bus_data = '0;
        done     = 1'b0;
        err      = 1'b0;
        unique case (state_q)
            S_CMD: begin
                bus_stb  = 1'b1;
                bus_kind = KIND_CMD;
                bus_data = first_w;
            end
            S_ADDR: begin
                bus_stb  = 1'b1;
                bus_kind = KIND_ADDR;
                bus_data = (amode_q == AM_ZERO1) ? '0 : pack_word;
            end
            S_CONF: begin
                bus_stb  = 1'b1;
                bus_kind = KIND_CMD;
                bus_data = conf_w;
            end
            S_DONE:   done = 1'b1;
            S_REJECT: err  = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/nand_seq_checker.sv
module nand_seq_checker
    import nand_seq_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [3:0]       req_op,
    input logic             dev_rdy,
    input logic             bus_stb,
    input logic [1:0]       bus_kind,
    input logic [BUS_W-1:0] bus_data,
    input logic             done,
    input logic             err
);

    assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_stb && !done && !err));

    assert_open_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ((bus_stb && bus_kind == KIND_CMD) || err));

    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stb |-> ((bus_data >> 8) == '0));

    assert_busy_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !dev_rdy) |->
            (req_op == OP_STATUS || req_op == OP_RESET || req_op == OP_CREAD_START ||
             req_op == OP_CREAD_EXIT || req_op > OP_CREAD_EXIT));

    assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!err && !bus_stb && !done));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_kind_tag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stb ? (bus_kind == KIND_CMD || bus_kind == KIND_ADDR) : (bus_kind == KIND_NONE));

endmodule

bind nand_cmd_seq nand_seq_checker #(.BUS_W(BUS_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .dev_rdy   (dev_rdy),
    .bus_stb   (bus_stb),
    .bus_kind  (bus_kind),
    .bus_data  (bus_data),
    .done      (done),
    .err       (err)
);

// File: tb/test_nand_cmd_seq.sv
module test_nand_cmd_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_op = 4'd0;
    logic [28:0] req_addr = '0;
    logic        req_wide = 1'b0;
    logic        dev_rdy;
    logic        bus_stb;
    logic [1:0]  bus_kind;
    logic [15:0] bus_data;
    logic        done;
    logic        err;

    int total = 0;
    int bad = 0;
    int busy_cnt = 0;
    logic hold_busy = 1'b0;
    int cyc = 0;

    always #10 clk = ~clk;

    nand_cmd_seq i_nand_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wide(req_wide), .dev_rdy(dev_rdy),
        .bus_stb(bus_stb), .bus_kind(bus_kind), .bus_data(bus_data),
        .done(done), .err(err)
    );

    assign dev_rdy = (busy_cnt == 0) && !hold_busy;

    // device model: array-start confirms make the part busy for a while
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (bus_stb && bus_kind == 2'd1 &&
            (bus_data == 16'h30 || bus_data == 16'h35 || bus_data == 16'h10 ||
             bus_data == 16'h15 || bus_data == 16'hD0 || bus_data == 16'h31))
            busy_cnt <= 2 + int'($urandom_range(6));
        else if (busy_cnt > 0)
            busy_cnt <= busy_cnt - 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd11: return 7;
            4'd5:  return 5;
            4'd6:  return 4;
            4'd7:  return 3;
            4'd8:  return 2;
            4'd9, 4'd10, 4'd12: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_reject(input logic [3:0] op, input logic w);
        return (op > 4'd12) || (w && (op == 4'd11 || op == 4'd12));
    endfunction

    function automatic bit exp_wait(input logic [3:0] op);
        return (op <= 4'd5) || (op == 4'd11);
    endfunction

    // returns {kind, data} of cycle i
    function automatic logic [17:0] exp_cycle(input logic [3:0] op, input logic [28:0] a,
                                              input logic w, input int i);
        logic [7:0] ab [5];
        logic [7:0] op1, op2;
        logic [17:0] seq [7];
        int n;
        if (!w) begin
            ab[0] = a[7:0]; ab[1] = {4'b0, a[11:8]}; ab[2] = a[19:12];
            ab[3] = a[27:20]; ab[4] = {7'b0, a[28]};
        end else begin
            ab[0] = a[7:0]; ab[1] = {5'b0, a[10:8]}; ab[2] = a[18:11];
            ab[3] = a[26:19]; ab[4] = {7'b0, a[27]};
        end
        op2 = 8'h00;
        case (op)
            4'd0: begin op1 = 8'h00; op2 = 8'h30; end
            4'd1: begin op1 = 8'h00; op2 = 8'h35; end
            4'd2: begin op1 = 8'h80; op2 = 8'h10; end
            4'd3: begin op1 = 8'h80; op2 = 8'h15; end
            4'd4: begin op1 = 8'h85; op2 = 8'h10; end
            4'd5: begin op1 = 8'h60; op2 = 8'hD0; end
            4'd6: begin op1 = 8'h05; op2 = 8'hE0; end
            4'd7: op1 = 8'h85;
            4'd8: op1 = 8'h90;
            4'd9: op1 = 8'h70;
            4'd10: op1 = 8'hFF;
            4'd11: begin op1 = 8'h00; op2 = 8'h31; end
            default: op1 = 8'h34;
        endcase
        for (int k = 0; k < 7; k++) seq[k] = '0;
        seq[0] = {2'd1, 8'h00, op1};
        n = 1;
        case (op)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd11:
                for (int k = 0; k < 5; k++) begin seq[n] = {2'd2, 8'h00, ab[k]}; n++; end
            4'd5:
                for (int k = 2; k < 5; k++) begin seq[n] = {2'd2, 8'h00, ab[k]}; n++; end
            4'd6, 4'd7:
                for (int k = 0; k < 2; k++) begin seq[n] = {2'd2, 8'h00, ab[k]}; n++; end
            4'd8: begin seq[n] = {2'd2, 16'h0000}; n++; end
            default: ;
        endcase
        if (op2 != 8'h00) seq[n] = {2'd1, 8'h00, op2};
        return seq[i];
    endfunction

    task automatic run_op(input logic [3:0] op, input logic [28:0] a, input logic w,
                          input bit hold);
        int got = 0;
        int last_stb = -1;
        int done_at = -1;
        bit err_seen = 0;
        bit low_seen = 0;
        bit busy_ok = (op == 4'd9 || op == 4'd10) || exp_reject(op, w);
        logic [17:0] e;
        hold_busy = hold;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wide = w;
        #1;
        if (hold) begin
            if (busy_ok) begin
                check(req_ready == 1'b1, "R6", "busy-allowed request ready", req_ready, 1);
            end else begin
                for (int k = 0; k < 6; k++) begin
                    check(!req_ready && !bus_stb, "R6", "gated request held",
                          {req_ready, bus_stb}, 0);
                    @(negedge clk);
                end
                hold_busy = 1'b0;
                #1;
            end
        end
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 1'b0;
        for (int t = 0; t < 400; t++) begin
            @(negedge clk);
            if (!dev_rdy) low_seen = 1;
            if (bus_stb) begin
                e = exp_cycle(op, a, w, got);
                check(got < exp_len(op) && {bus_kind, bus_data} == e, "R2/R3/R4/R5/R10",
                      $sformatf("cycle %0d op %0d wide %0d", got, op, w), {bus_kind, bus_data}, e);
                last_stb = t;
                got++;
            end
            if (err) begin err_seen = 1; break; end
            if (done) begin done_at = t; break; end
        end
        hold_busy = 1'b0;
        if (exp_reject(op, w)) begin
            check(err_seen && got == 0 && done_at < 0, "R7", $sformatf("refusal op %0d", op),
                  {err_seen, got[7:0]}, 9'h100);
        end else begin
            check(!err_seen, "R7", "unexpected err", err_seen, 0);
            check(got == exp_len(op), "R5", $sformatf("cycle count op %0d", op), got, exp_len(op));
            check(done_at >= 0, "R9", "done seen", done_at, 0);
            if (exp_wait(op)) begin
                check(low_seen && dev_rdy, "R8", $sformatf("done after busy cycle op %0d", op),
                      {low_seen, dev_rdy}, 2'b11);
            end else begin
                check(done_at == last_stb + 1, "R9", $sformatf("done right after last op %0d", op),
                      done_at, last_stb + 1);
            end
            @(negedge clk);
            check(!done, "R9", "done one clock", done, 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_stb && !done && !err && bus_kind == 2'd0 && req_ready, "R1", "reset state",
              {bus_stb, done, err, bus_kind, req_ready}, 6'b000001);

        run_op(4'd0, 29'h1ABCDEF0, 1'b0, 0);   // R3 page read byte-wide, top bit set
        run_op(4'd0, 29'h1ABCDEF0, 1'b1, 0);   // R4 word-wide packing
        run_op(4'd5, 29'h0FEDC123, 1'b0, 0);   // R5 row-only erase
        run_op(4'd8, 29'h1FFFFFFF, 1'b0, 0);   // R5 single zero address
        run_op(4'd9, 29'h0, 1'b0, 1);          // R6 status while busy
        run_op(4'd10, 29'h0, 1'b1, 1);         // R6 reset while busy
        run_op(4'd2, 29'h00345678, 1'b0, 1);   // R6 program held by busy
        run_op(4'd11, 29'h00000FFF, 1'b1, 0);  // R7 cache read in word-wide mode
        run_op(4'd12, 29'h0, 1'b1, 1);         // R7 refused even while busy
        run_op(4'd14, 29'h0, 1'b0, 0);         // R7 undefined code
        run_op(4'd11, 29'h00000FFF, 1'b0, 0);  // R8 cache read start byte-wide
        run_op(4'd12, 29'h0, 1'b0, 0);         // R9 cache read exit
        run_op(4'd7, 29'h00000ABC, 1'b1, 0);   // R5 column-only input

        for (int n = 0; n < 80; n++) begin
            run_op(4'($urandom_range(15)), 29'($urandom), 1'($urandom_range(1)),
                   ($urandom_range(3) == 0));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule